// File: doc/BRIEF.md
# Low-Power Escape-Mode Long-Write Transmitter

This block sends one register write to a display bridge over a single serial data lane. The lane is in its low-power signalling state, and the block drives the two single-ended line levels of the lane directly. A request carries a data type, a register address and a register value. The block latches the request. It then builds a complete long-write packet: a header with a word count and a Hamming-style check byte, a payload made of the address and the value, and a 16-bit payload checksum.

Before the packet, the block places the lane in escape mode and sends the command byte that selects low-power data transmission. It then sends every packet byte with spaced-one-hot line coding and finally returns the lane to its stop state. External resistors or buffers shift the two line outputs to the lane's electrical levels.

A sequencer that powers a panel up issues one request for each register, waits for the busy flag to drop, and then issues the next request. The time spent in each line state is a parameter, so one design can serve many clock rates.

Top module: `dsi_lpdt_tx`

## Requirements
- R1: Out of reset, and whenever busy is low, both line outputs are high (stop state, `lp_dp`=1, `lp_dn`=1).
- R2: Escape entry drives the line pair {`lp_dp`,`lp_dn`} through 10, 00, 01, 00 after leaving stop. The first byte sent is then the command 0x87, which as bits in time order is 1,1,1,0,0,0,0,1.
- R3: The header follows the command: the request's data type, then the word count 0x06 and 0x00 (low byte first).
- R4: The fifth byte is the header check code. Bit i (i=0..5) is the XOR of the 24 header bits {wc_hi, wc_lo, dtype} selected by the standard 6-bit lane-packet mask for bit i, and bits 7:6 are zero. For data type 0x29 with word count 6 the code is 0x23.
- R5: Six payload bytes follow: the address low byte then high byte, then the 32-bit value from its least significant byte to its most significant.
- R6: Two checksum bytes close the packet, low byte first. The checksum is a CRC over the payload only, with polynomial x^16+x^12+x^5+1, preset 0xFFFF, and data bits taken LSB first. For a payload of 10 02 03 00 00 00 the two bytes are 0x85, 0x79.
- R7: Each byte is sent LSB first. A 1 is sent as line pair 10 and a 0 as line pair 01, and every bit is followed by a space of 00.
- R8: After the last space, the lane goes to 10 and then to 11, and busy falls in the same cycle that the stop state returns.
- R9: Every line state inside a transfer lasts exactly HOLD_CYC clock cycles, so busy stays high for 213×HOLD_CYC cycles.
- R10: While busy is high the lane never shows the stop state. A request raised during that time is dropped: it changes neither the packet in flight nor the lane after the packet ends.
- R11: A request seen with busy low is accepted at that clock edge. In the next cycle busy is high and the line pair is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_dtype | input | 8 | Packet data type (0x29 for a generic long write) |
| req_addr | input | ADDR_W | Register address |
| req_data | input | DATA_W | Register value |
| busy | output | 1 | High from acceptance until the lane is back in stop |
| lp_dp | output | 1 | Positive-line low-power level |
| lp_dn | output | 1 | Negative-line low-power level |

## Verification
The bench builds the block with HOLD_CYC set to 3 and keeps the address and value widths at 16 and 32 bits. Three cycles per state is odd and greater than one, so the generated hold counter is used and its terminal count is exercised. An off-by-one in that counter changes both the run length of each state and the 639-cycle busy window. With the default widths the packet has thirteen bytes, and three of the stimulus payloads have checksums that are known in advance. This lets the decoded waveform be compared against fixed bytes as well as against a model computed in the bench.

// File: rtl/dsi_lpdt_pkg.sv
package dsi_lpdt_pkg;

   // line pair encoded as {dp, dn}
   typedef logic [1:0] lp_pair_t;

   localparam lp_pair_t LP_STOP  = 2'b11;
   localparam lp_pair_t LP_MARK1 = 2'b10;
   localparam lp_pair_t LP_MARK0 = 2'b01;
   localparam lp_pair_t LP_SPACE = 2'b00;

   // low-power data command, sent LSB first: 1,1,1,0,0,0,0,1
   localparam logic [7:0] LPDT_CMD_BYTE = 8'h87;

   // bytes that surround the payload: command, type, two count bytes, check code, two crc bytes
   localparam int FRAME_OVERHEAD = 7;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ENTRY,
      SQ_MARK,
      SQ_SPACE,
      SQ_EXIT
   } seq_state_t;

   // escape entry pattern after leaving stop
   function automatic lp_pair_t entry_level(input logic [1:0] step);
      case (step)
         2'd0:    entry_level = LP_MARK1;
         2'd1:    entry_level = LP_SPACE;
         2'd2:    entry_level = LP_MARK0;
         default: entry_level = LP_SPACE;
      endcase
   endfunction

   // header bits covered by each check-code bit
   function automatic logic [23:0] ecc_cover(input int idx);
      case (idx)
         0:       ecc_cover = 24'hF12CB7;
         1:       ecc_cover = 24'hF2555B;
         2:       ecc_cover = 24'h749A6D;
         3:       ecc_cover = 24'hB8E38E;
         4:       ecc_cover = 24'hDF03F0;
         default: ecc_cover = 24'hEFFC00;
      endcase
   endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc
   import dsi_lpdt_pkg::*;
(
   input  logic [23:0] hdr_bits,
   output logic [7:0]  ecc_byte
);

   for (genvar gi = 0; gi < 6; gi++) begin : g_par
      assign ecc_byte[gi] = ^(hdr_bits & ecc_cover(gi));
   end

   assign ecc_byte[7:6] = 2'b00;

endmodule

// File: rtl/dsi_payload_crc.sv
module dsi_payload_crc #(
   parameter int          NBYTES = 6,
   parameter logic [15:0] PRESET = 16'hFFFF,
   parameter logic [15:0] POLY_R = 16'h8408
) (
   input  logic [NBYTES*8-1:0] pay,
   output logic [15:0]         crc
);

   if (NBYTES < 1) begin : g_bad_len
      $error("dsi_payload_crc: NBYTES must be at least 1");
   end

   logic [15:0] acc;
   logic        fb;

   always_comb begin
      acc = PRESET;
      fb  = 1'b0;
      for (int b = 0; b < NBYTES; b++) begin
         for (int k = 0; k < 8; k++) begin
            fb  = acc[0] ^ pay[b*8+k];
            acc = {1'b0, acc[15:1]};
            if (fb) acc = acc ^ POLY_R;
         end
      end
      crc = acc;
   end

endmodule

// File: rtl/dsi_lpdt_framer.sv
module dsi_lpdt_framer
   import dsi_lpdt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int PAY_BYTES = (ADDR_W + DATA_W) / 8,
   localparam int TOT_BYTES = PAY_BYTES + FRAME_OVERHEAD,
   localparam int BW        = (TOT_BYTES > 1) ? $clog2(TOT_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [7:0]        dtype,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [BW-1:0]     byte_idx,
   output logic [7:0]        byte_out
);

   localparam logic [15:0] WC = 16'(PAY_BYTES);

   logic [7:0]        dt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dt_q   <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         dt_q   <= dtype;
         addr_q <= addr;
         data_q <= data;
      end
   end

   logic [PAY_BYTES*8-1:0] pay;
   logic [7:0]             ecc;
   logic [15:0]            crc;

   assign pay = {data_q, addr_q};

   dsi_hdr_ecc u_ecc (
      .hdr_bits ({WC[15:8], WC[7:0], dt_q}),
      .ecc_byte (ecc)
   );

   dsi_payload_crc #(.NBYTES(PAY_BYTES)) u_crc (
      .pay (pay),
      .crc (crc)
   );

   logic [TOT_BYTES*8-1:0] stream;
   logic [7:0]             bytes [TOT_BYTES];

   assign stream = {crc, pay, ecc, WC[15:8], WC[7:0], dt_q, LPDT_CMD_BYTE};

   for (genvar gb = 0; gb < TOT_BYTES; gb++) begin : g_slice
      assign bytes[gb] = stream[gb*8 +: 8];
   end

   assign byte_out = bytes[byte_idx];

endmodule

// File: rtl/dsi_lpdt_lineseq.sv
module dsi_lpdt_lineseq
   import dsi_lpdt_pkg::*;
#(
   parameter int HOLD_CYC = 4,
   parameter int NBYTES   = 13,
   localparam int BW      = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int HW      = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    cur_byte,
   output logic [BW-1:0] byte_idx,
   output logic          busy,
   output logic          lp_dp,
   output logic          lp_dn
);

   seq_state_t state;
   lp_pair_t   line;
   logic [1:0] ent_step;
   logic [2:0] bit_idx;
   logic       last_bit;
   logic       hold_done;
   logic       active;

   assign active = (state != SQ_IDLE);

   if (HOLD_CYC == 1) begin : g_no_hold
      assign hold_done = 1'b1;
   end else begin : g_hold
      logic [HW-1:0] hold_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               hold_cnt <= '0;
         else if (!active || hold_cnt == HW'(HOLD_CYC - 1)) hold_cnt <= '0;
         else                                      hold_cnt <= hold_cnt + 1'b1;
      end
      assign hold_done = (hold_cnt == HW'(HOLD_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         line     <= LP_STOP;
         ent_step <= '0;
         bit_idx  <= '0;
         byte_idx <= '0;
         last_bit <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  state    <= SQ_ENTRY;
                  line     <= entry_level(2'd0);
                  ent_step <= '0;
                  bit_idx  <= '0;
                  byte_idx <= '0;
                  last_bit <= 1'b0;
               end
            end
            SQ_ENTRY: begin
               if (hold_done) begin
                  if (ent_step == 2'd3) begin
                     state <= SQ_MARK;
                     line  <= cur_byte[bit_idx] ? LP_MARK1 : LP_MARK0;
                  end else begin
                     ent_step <= ent_step + 1'b1;
                     line     <= entry_level(ent_step + 1'b1);
                  end
               end
            end
            SQ_MARK: begin
               if (hold_done) begin
                  state <= SQ_SPACE;
                  line  <= LP_SPACE;
                  if (bit_idx == 3'd7) begin
                     bit_idx <= '0;
                     if (byte_idx == BW'(NBYTES - 1)) last_bit <= 1'b1;
                     else                             byte_idx <= byte_idx + 1'b1;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            SQ_SPACE: begin
               if (hold_done) begin
                  if (last_bit) begin
                     state <= SQ_EXIT;
                     line  <= LP_MARK1;
                  end else begin
                     state <= SQ_MARK;
                     line  <= cur_byte[bit_idx] ? LP_MARK1 : LP_MARK0;
                  end
               end
            end
            SQ_EXIT: begin
               if (hold_done) begin
                  state <= SQ_IDLE;
                  line  <= LP_STOP;
               end
            end
            default: begin
               state <= SQ_IDLE;
               line  <= LP_STOP;
            end
         endcase
      end
   end

   assign busy  = active;
   assign lp_dp = line[1];
   assign lp_dn = line[0];

endmodule

// File: rtl/dsi_lpdt_tx.sv
module dsi_lpdt_tx
   import dsi_lpdt_pkg::*;
#(
   parameter int HOLD_CYC = 4,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_dtype,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              lp_dp,
   output logic              lp_dn
);

   localparam int PAY_BYTES = (ADDR_W + DATA_W) / 8;
   localparam int TOT_BYTES = PAY_BYTES + FRAME_OVERHEAD;
   localparam int BW        = (TOT_BYTES > 1) ? $clog2(TOT_BYTES) : 1;

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("dsi_lpdt_tx: HOLD_CYC must be at least 1");
   end
   if ((ADDR_W % 8) != 0 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("dsi_lpdt_tx: address and value widths must be whole bytes");
   end
   if (ADDR_W < 8 || DATA_W < 8) begin : g_bad_small
      $error("dsi_lpdt_tx: address and value need at least one byte each");
   end

   logic          start;
   logic [BW-1:0] byte_idx;
   logic [7:0]    cur_byte;

   assign start = req_valid && !busy;

   dsi_lpdt_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .dtype    (req_dtype),
      .addr     (req_addr),
      .data     (req_data),
      .byte_idx (byte_idx),
      .byte_out (cur_byte)
   );

   dsi_lpdt_lineseq #(.HOLD_CYC(HOLD_CYC), .NBYTES(TOT_BYTES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cur_byte (cur_byte),
      .byte_idx (byte_idx),
      .busy     (busy),
      .lp_dp    (lp_dp),
      .lp_dn    (lp_dn)
   );

endmodule

// File: rtl/dsi_lpdt_tx_chk.sv
module dsi_lpdt_tx_chk #(
   parameter int HOLD_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic lp_dp,
   input logic lp_dn
);

   localparam int CW = $clog2(HOLD_CYC + 2) + 1;

   logic [1:0]    prev_lv;
   logic [CW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lv <= 2'b11;
         run_len <= '0;
      end else begin
         prev_lv <= {lp_dp, lp_dn};
         if ({lp_dp, lp_dn} != prev_lv)  run_len <= CW'(1);
         else if (run_len != '1)         run_len <= run_len + 1'b1;
      end
   end

   // R1
   idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (lp_dp && lp_dn));

   // R10
   busy_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(lp_dp && lp_dn));

   // R11
   accept_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (busy && lp_dp && !lp_dn));

   // R8
   exit_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(lp_dp && !lp_dn));

   // R7
   space_not_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!lp_dp && !lp_dn) |-> !(lp_dp && lp_dn));

   // R9
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (({lp_dp, lp_dn} != prev_lv) && $past(busy)) |-> (run_len == CW'(HOLD_CYC)));

endmodule

bind dsi_lpdt_tx dsi_lpdt_tx_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .lp_dp     (lp_dp),
   .lp_dn     (lp_dn)
);

// File: tb/dsi_lpdt_tx_tb.sv
module dsi_lpdt_tx_tb;

   localparam int H    = 3;
   localparam int NB   = 13;
   localparam int NSEQ = 4 + NB * 16 + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_dtype = '0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_data = '0;
   wire         busy, lp_dp, lp_dn;

   always #10 clk = ~clk;

   dsi_lpdt_tx #(.HOLD_CYC(H), .ADDR_W(16), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dtype(req_dtype),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .lp_dp(lp_dp), .lp_dn(lp_dn)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [1:0] seq [300];
   int         nseq = 0;
   int         busy_cyc = 0;
   logic [1:0] last_lv = 2'b11;
   bit         cap_clr = 1'b0;

   always @(negedge clk) begin
      if (cap_clr) begin
         nseq = 0; busy_cyc = 0; last_lv = 2'b11;
      end else begin
         if ({lp_dp, lp_dn} != last_lv) begin
            if (nseq < 300) seq[nseq] = {lp_dp, lp_dn};
            nseq++;
         end
         last_lv = {lp_dp, lp_dn};
         if (busy) busy_cyc++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] model_crc(input logic [47:0] p);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < 48; i++) begin
         logic t = c[0] ^ p[i];
         c = c >> 1;
         if (t) c = c ^ 16'h8408;
      end
      return c;
   endfunction

   function automatic logic [7:0] model_ecc(input logic [23:0] h);
      logic [23:0] m [6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};
      logic [7:0] e = '0;
      for (int i = 0; i < 6; i++) e[i] = ^(h & m[i]);
      return e;
   endfunction

   task automatic send_check(input logic [7:0] dt, input logic [15:0] a, input logic [31:0] d,
                             input bit fixed, input logic [15:0] fixed_crc,
                             input bit inject, input string name);
      logic [7:0]  exp [NB];
      logic [7:0]  got [NB];
      logic [15:0] crc;
      bit          coding_ok = 1'b1;
      bit          ok;
      crc = fixed ? fixed_crc : model_crc({d, a});
      exp[0] = 8'h87; exp[1] = dt; exp[2] = 8'h06; exp[3] = 8'h00;
      exp[4] = model_ecc({8'h00, 8'h06, dt});
      exp[5] = a[7:0]; exp[6] = a[15:8];
      exp[7] = d[7:0]; exp[8] = d[15:8]; exp[9] = d[23:16]; exp[10] = d[31:24];
      exp[11] = crc[7:0]; exp[12] = crc[15:8];

      @(posedge clk) cap_clr = 1'b1;
      @(posedge clk) cap_clr = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_dtype = dt; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      // R11 accepted: busy and LP-10 in the following cycle
      chk(busy && lp_dp && !lp_dn, "R11", {name, " accept"}, {busy, lp_dp, lp_dn}, 3'b110);
      if (inject) begin
         repeat (100) @(negedge clk);
         req_valid = 1'b1; req_dtype = 8'h05; req_addr = 16'hFFFF; req_data = 32'h12345678;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (busy) @(negedge clk);
      @(posedge clk);

      chk(nseq == NSEQ, "R9", {name, " state count"}, nseq, NSEQ);
      if (nseq == NSEQ) begin
         ok = (seq[0] == 2'b10) && (seq[1] == 2'b00) && (seq[2] == 2'b01) && (seq[3] == 2'b00);
         chk(ok, "R2", {name, " entry"}, {seq[0], seq[1], seq[2], seq[3]}, 8'b10000100);
         for (int b = 0; b < NB; b++) begin
            got[b] = '0;
            for (int k = 0; k < 8; k++) begin
               logic [1:0] mk = seq[4 + 2 * (b * 8 + k)];
               logic [1:0] sp = seq[5 + 2 * (b * 8 + k)];
               if (!((mk == 2'b10 || mk == 2'b01) && sp == 2'b00)) coding_ok = 1'b0;
               got[b][k] = (mk == 2'b10);
            end
         end
         chk(coding_ok, "R7", {name, " spaced one-hot"}, coding_ok, 1);
         chk(got[0] == 8'h87, "R2", {name, " command"}, got[0], 8'h87);
         chk({got[1], got[2], got[3]} == {exp[1], exp[2], exp[3]}, "R3", {name, " header"},
             {got[1], got[2], got[3]}, {exp[1], exp[2], exp[3]});
         chk(got[4] == exp[4], "R4", {name, " ecc"}, got[4], exp[4]);
         if (dt == 8'h29) chk(got[4] == 8'h23, "R4", {name, " ecc fixed"}, got[4], 8'h23);
         chk({got[10], got[9], got[8], got[7], got[6], got[5]} == {d, a}, "R5", {name, " payload"},
             {got[10], got[9], got[8], got[7], got[6], got[5]}, {d, a});
         chk({got[12], got[11]} == crc, "R6", {name, " crc"}, {got[12], got[11]}, crc);
         chk(seq[NSEQ-2] == 2'b10 && seq[NSEQ-1] == 2'b11, "R8", {name, " exit"},
             {seq[NSEQ-2], seq[NSEQ-1]}, 4'b1011);
      end
      chk(busy_cyc == 213 * H, "R9", {name, " busy length"}, busy_cyc, 213 * H);
      if (inject) begin
         repeat (40) @(negedge clk);
         chk(!busy && lp_dp && lp_dn, "R10", {name, " no second packet"}, {busy, lp_dp, lp_dn}, 3'b011);
         chk(nseq == NSEQ, "R10", {name, " lane quiet"}, nseq, NSEQ);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!busy, "R1", "reset busy", busy, 0);
      chk(lp_dp && lp_dn, "R1", "reset stop", {lp_dp, lp_dn}, 2'b11);
   endtask

   task automatic t_known_a;   // R6 stated example 85 79
      send_check(8'h29, 16'h0210, 32'h00000003, 1'b1, 16'h7985, 1'b0, "known_a");
   endtask

   task automatic t_known_b;
      send_check(8'h29, 16'h0164, 32'h00000005, 1'b1, 16'hFA7E, 1'b0, "known_b");
   endtask

   task automatic t_known_c;
      send_check(8'h29, 16'h0428, 32'h003D0320, 1'b1, 16'hE7B5, 1'b0, "known_c");
   endtask

   task automatic t_other_type;
      send_check(8'h39, 16'hBEEF, 32'hA5C30F81, 1'b0, 16'h0, 1'b0, "other_type");
   endtask

   task automatic t_ignore_busy;   // R10
      send_check(8'h29, 16'h0004, 32'h00000001, 1'b0, 16'h0, 1'b1, "ignore_busy");
   endtask

   task automatic t_back_to_back;
      send_check(8'h29, 16'hFFFF, 32'hFFFFFFFF, 1'b0, 16'h0, 1'b0, "b2b_ones");
      send_check(8'h29, 16'h0000, 32'h00000000, 1'b0, 16'h0, 1'b0, "b2b_zeros");
      chk(!busy && lp_dp && lp_dn, "R1", "idle after b2b", {busy, lp_dp, lp_dn}, 3'b011);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog R9: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_known_a();
      t_known_b();
      t_known_c();
      t_other_type();
      t_ignore_busy();
      t_back_to_back();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule